// File: doc/BRIEF.md
# Accumulator-Style Stored-Program Processor

This block is a very small processor. Its program and its data share one byte-addressed memory, which sits outside the block behind a synchronous single-port interface. That interface has an address, write data, read data and a write enable, and read data returns one clock after the address is presented. The core holds these pieces:

- a program counter
- an instruction register
- two 16-bit working registers, AX and BX
- an adder
- a phase sequencer that takes every instruction through fetch, decode, execute and, when a register result is produced, a write-back step

Only two instructions exist. MOV transfers a 16-bit word between a working register and memory, in either direction. ADD adds a memory word into a working register. Every other opcode is a no-operation. Words in memory are little-endian: the lower-addressed byte is the less significant one.

The core exposes both working registers, the program counter and a one-cycle retire strobe. These outputs let an environment follow execution one instruction at a time.

Top module: `toy_acc_cpu`

## Requirements
- R1: While reset is held, and on the first clock after it is released, the program counter, AX and BX read zero and the memory write enable is low.
- R2: In the fetch phase the memory address equals the program counter and the write enable is low. The program counter changes only once per instruction, by adding 2 during decode, and wraps modulo 2^ADDR_W.
- R3: An instruction is the 16-bit word at the program counter, with its low byte at the program counter address. Bits [15:14] are the opcode, bits [13:7] are field A and bits [6:0] are field B.
- R4: A load is opcode 01 with field A holding a register code (1 selects AX, 2 selects BX). It copies the little-endian word at byte address B into that register. Odd addresses are allowed.
- R5: A store is opcode 01 with field A not a register code and field B a register code. It writes that register to byte address A, low byte at A and high byte at A+1, with the write enable high for exactly one cycle.
- R6: ADD (opcode 11) with field A a register code replaces that register with the register plus the memory word at address B, modulo 2^16.
- R7: Opcodes 00 and 10 change no register, write no memory and only advance the program counter.
- R8: A MOV whose fields are both non-register codes writes nothing. An ADD whose field A is not a register code changes no register.
- R9: Loads and ADDs take 4 cycles and every other instruction takes 3. The retire output is high for exactly one cycle per instruction, in its last cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Byte address to memory |
| mem_wdata | output | 16 | Store data, little-endian word |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Word read from mem_addr one cycle earlier |
| ax_out | output | 16 | Current AX |
| bx_out | output | 16 | Current BX |
| pc_out | output | ADDR_W | Current program counter |
| retire | output | 1 | Last cycle of an instruction |

## Verification
The bench checks MOV direction decoding in both directions. If the sequencer used field A without first checking it against the register codes, a load would show up as a memory write, or a store would corrupt a register. Loads from odd addresses and stores near the top of the data area catch a byte-order swap or a wrong high-byte address. An ADD that wraps past 0xFFFF catches an adder that is too wide. Undefined opcodes and MOV or ADD with non-register fields catch a write-back step that runs when it should not. Cycle counts between retire pulses expose a missing or an extra phase.

// File: rtl/toy_cpu_pkg.sv
package toy_cpu_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 7;

  localparam logic [FIELD_W-1:0] CODE_AX = 7'd1;
  localparam logic [FIELD_W-1:0] CODE_BX = 7'd2;

  typedef enum logic [1:0] {
    OPC_UNDEF0 = 2'b00,
    OPC_MOV    = 2'b01,
    OPC_UNDEF2 = 2'b10,
    OPC_ADD    = 2'b11
  } opcode_e;

  typedef struct packed {
    opcode_e            op;
    logic [FIELD_W-1:0] fa;
    logic [FIELD_W-1:0] fb;
  } instr_t;

  typedef enum logic [1:0] {
    PH_FETCH,
    PH_DECODE,
    PH_EXEC,
    PH_WB
  } phase_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_STORE,
    ACT_ADD
  } action_e;

  function automatic logic is_reg_code(logic [FIELD_W-1:0] f);
    return (f == CODE_AX) || (f == CODE_BX);
  endfunction

  // Maps an instruction word to what it does; field order sets MOV direction.
  function automatic action_e classify(instr_t i);
    action_e a;
    a = ACT_NONE;
    case (i.op)
      OPC_MOV: begin
        if (is_reg_code(i.fa))      a = ACT_LOAD;
        else if (is_reg_code(i.fb)) a = ACT_STORE;
      end
      OPC_ADD: if (is_reg_code(i.fa)) a = ACT_ADD;
      default: a = ACT_NONE;
    endcase
    return a;
  endfunction

  function automatic logic needs_writeback(action_e a);
    return (a == ACT_LOAD) || (a == ACT_ADD);
  endfunction
endpackage

// File: rtl/toy_cpu_alu.sv
module toy_cpu_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum
);
  // Carry out of the top bit is discarded: result is modulo 2^W.
  logic [W:0] full;
  always_comb begin
    full = {1'b0, opa} + {1'b0, opb};
    sum  = full[W-1:0];
  end
endmodule

// File: rtl/toy_cpu_regs.sv
module toy_cpu_regs #(
  parameter int W    = 16,
  parameter int NREG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [W-1:0]            wr_data,
  output logic [NREG-1:0][W-1:0]  rd_all
);
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rd_all[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        rd_all[g] <= wr_data;
    end
  end
endmodule

// File: rtl/toy_cpu_ctrl.sv
module toy_cpu_ctrl
  import toy_cpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   pc,
  output action_e             act,
  output logic                reg_we,
  output logic                dest_bx,
  output logic                src_bx,
  output logic                fetch_phase,
  output logic                pc_adv,
  output logic                retire
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  phase_e phase;
  instr_t ir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      case (phase)
        PH_FETCH:  phase <= PH_DECODE;
        PH_DECODE: begin
          ir    <= instr_t'(mem_rdata);
          pc    <= pc + PC_STEP;
          phase <= PH_EXEC;
        end
        PH_EXEC:   phase <= needs_writeback(act) ? PH_WB : PH_FETCH;
        default:   phase <= PH_FETCH;
      endcase
    end
  end

  always_comb begin
    act         = classify(ir);
    fetch_phase = (phase == PH_FETCH);
    pc_adv      = (phase == PH_DECODE);
    mem_we      = (phase == PH_EXEC) && (act == ACT_STORE);
    reg_we      = (phase == PH_WB);
    dest_bx     = (ir.fa == CODE_BX);
    src_bx      = (ir.fb == CODE_BX);
    retire      = (phase == PH_WB) ||
                  ((phase == PH_EXEC) && !needs_writeback(act));
    case (phase)
      PH_EXEC, PH_WB: mem_addr = (act == ACT_STORE) ? ADDR_W'(ir.fa) : ADDR_W'(ir.fb);
      default:        mem_addr = pc;
    endcase
  end
endmodule

// File: rtl/toy_acc_cpu.sv
module toy_acc_cpu
  import toy_cpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              mem_we,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       ax_out,
  output logic [15:0]       bx_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              retire
);
  localparam int NREG  = 2;
  localparam int SEL_W = $clog2(NREG);

  action_e                     act;
  logic                        reg_we;
  logic                        dest_bx;
  logic                        src_bx;
  logic                        fetch_phase;
  logic                        pc_adv;
  logic                        add_wr;
  logic [WORD_W-1:0]           alu_a;
  logic [WORD_W-1:0]           alu_sum;
  logic [WORD_W-1:0]           wb_data;
  logic [NREG-1:0][WORD_W-1:0] regs;

  toy_cpu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .pc          (pc_out),
    .act         (act),
    .reg_we      (reg_we),
    .dest_bx     (dest_bx),
    .src_bx      (src_bx),
    .fetch_phase (fetch_phase),
    .pc_adv      (pc_adv),
    .retire      (retire)
  );

  toy_cpu_alu #(.W(WORD_W)) u_alu (
    .opa (alu_a),
    .opb (mem_rdata),
    .sum (alu_sum)
  );

  toy_cpu_regs #(.W(WORD_W), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_sel  (SEL_W'(dest_bx)),
    .wr_data (wb_data),
    .rd_all  (regs)
  );

  always_comb begin
    alu_a     = dest_bx ? regs[1] : regs[0];
    wb_data   = (act == ACT_ADD) ? alu_sum : mem_rdata;
    add_wr    = reg_we && (act == ACT_ADD);
    mem_wdata = src_bx ? regs[1] : regs[0];
    ax_out    = regs[0];
    bx_out    = regs[1];
  end
endmodule

// File: rtl/toy_acc_cpu_checker.sv
module toy_acc_cpu_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [15:0]       mem_rdata,
  input logic [15:0]       ax_out,
  input logic [15:0]       bx_out,
  input logic [ADDR_W-1:0] pc_out,
  input logic              retire,
  input logic              fetch_phase,
  input logic              pc_adv,
  input logic              reg_we,
  input logic              add_wr,
  input logic              dest_bx
);
  p_reset_release_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc_out == '0 && ax_out == 16'd0 && bx_out == 16'd0 && !mem_we));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_phase |-> (mem_addr == pc_out && !mem_we));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |=> (pc_out == ADDR_W'($past(pc_out) + ADDR_W'(2))));

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_adv |=> $stable(pc_out));

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_add_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (add_wr && !dest_bx) |=> (ax_out == 16'($past(ax_out) + $past(mem_rdata))));

  p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(ax_out) && $stable(bx_out)));

  p_retire_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
endmodule

bind toy_acc_cpu toy_acc_cpu_checker #(.ADDR_W(ADDR_W)) u_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_addr    (mem_addr),
  .mem_we      (mem_we),
  .mem_rdata   (mem_rdata),
  .ax_out      (ax_out),
  .bx_out      (bx_out),
  .pc_out      (pc_out),
  .retire      (retire),
  .fetch_phase (fetch_phase),
  .pc_adv      (pc_adv),
  .reg_we      (reg_we),
  .add_wr      (add_wr),
  .dest_bx     (dest_bx)
);

// File: tb/toy_acc_cpu_test.sv
module toy_acc_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_PROGS    = 16;
  localparam int N_INSTR    = 30;
  localparam int LOAD_TOP   = 136;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = 16'd0;
  logic [15:0] ax_out, bx_out;
  logic [7:0]  pc_out;
  logic        retire;

  always #(CLK_PERIOD/2) clk = ~clk;

  toy_acc_cpu #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .ax_out(ax_out), .bx_out(bx_out),
    .pc_out(pc_out), .retire(retire)
  );

  // Memory model: synchronous single port, one-cycle read, little-endian words.
  logic [7:0] mem [256];
  logic       ld_en = 1'b0;
  logic [7:0] ld_addr = 8'd0;
  logic [7:0] ld_byte = 8'd0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_byte;
    else if (mem_we) begin
      mem[mem_addr]        <= mem_wdata[7:0];
      mem[mem_addr + 8'd1] <= mem_wdata[15:8];
    end
    mem_rdata <= {mem[mem_addr + 8'd1], mem[mem_addr]};
  end

  // Reference state
  logic [7:0]  ref_mem [256];
  logic [15:0] r_ax, r_bx;
  logic [7:0]  r_pc;
  int          exp_we, exp_len;
  string       exp_tag;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic [1:0] op, logic [6:0] a, logic [6:0] b);
    return {op, a, b};
  endfunction

  function automatic logic [15:0] ref_rd16(logic [7:0] a);
    logic [7:0] a1;
    a1 = a + 8'd1;
    return {ref_mem[a1], ref_mem[a]};
  endfunction

  task automatic ref_put16(logic [7:0] a, logic [15:0] w);
    logic [7:0] a1;
    a1 = a + 8'd1;
    ref_mem[a]  = w[7:0];
    ref_mem[a1] = w[15:8];
  endtask

  function automatic bit is_rc(logic [6:0] f);
    return f == 7'd1 || f == 7'd2;
  endfunction

  // Reference step: restates the instruction rules independently.
  task automatic ref_step();
    logic [15:0] w, v;
    logic [1:0]  op;
    logic [6:0]  fa, fb;
    w  = ref_rd16(r_pc);
    r_pc = r_pc + 8'd2;
    op = w[15:14]; fa = w[13:7]; fb = w[6:0];
    exp_we = 0; exp_len = 3; exp_tag = "R7";
    if (op == 2'b01) begin
      if (is_rc(fa)) begin
        v = ref_rd16({1'b0, fb});
        if (fa == 7'd1) r_ax = v; else r_bx = v;
        exp_len = 4; exp_tag = "R4";
      end else if (is_rc(fb)) begin
        ref_put16({1'b0, fa}, (fb == 7'd1) ? r_ax : r_bx);
        exp_we = 1; exp_tag = "R5";
      end else exp_tag = "R8";
    end else if (op == 2'b11) begin
      if (is_rc(fa)) begin
        v = ref_rd16({1'b0, fb});
        if (fa == 7'd1) r_ax = r_ax + v; else r_bx = r_bx + v;
        exp_len = 4; exp_tag = "R6";
      end else exp_tag = "R8";
    end
  endtask

  function automatic logic [6:0] rnd_reg();
    return ($urandom_range(0, 1) == 0) ? 7'd1 : 7'd2;
  endfunction

  function automatic logic [15:0] rnd_instr();
    int k;
    k = $urandom_range(0, 9);
    if (k <= 2) return enc(2'b01, rnd_reg(), 7'(64 + $urandom_range(0, 63)));
    if (k <= 4) return enc(2'b01, 7'(64 + $urandom_range(0, 62)), rnd_reg());
    if (k == 5) return enc(2'b01, 7'(64 + $urandom_range(0, 62)), 7'($urandom_range(3, 63)));
    if (k <= 7) return enc(2'b11, rnd_reg(), 7'(64 + $urandom_range(0, 63)));
    if (k == 8) return enc(2'b11, 7'(64 + $urandom_range(0, 62)), 7'(64 + $urandom_range(0, 63)));
    return enc(($urandom_range(0, 1) == 0) ? 2'b00 : 2'b10,
               7'($urandom_range(0, 127)), 7'($urandom_range(0, 127)));
  endfunction

  task automatic gen_random();
    for (int i = 0; i < N_INSTR; i++) ref_put16(8'(2*i), rnd_instr());
    for (int i = 2*N_INSTR; i < LOAD_TOP; i++) ref_mem[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic gen_directed();
    for (int i = 0; i < LOAD_TOP; i++) ref_mem[i] = 8'h00;
    ref_put16(8'd0,  enc(2'b01, 7'd1,  7'd64));   // load AX
    ref_put16(8'd2,  enc(2'b11, 7'd1,  7'd66));   // AX += 2
    ref_put16(8'd4,  enc(2'b01, 7'd68, 7'd1));    // store AX
    ref_put16(8'd6,  enc(2'b01, 7'd2,  7'd70));   // load BX = FFFF
    ref_put16(8'd8,  enc(2'b11, 7'd2,  7'd72));   // BX += 2 wraps
    ref_put16(8'd10, enc(2'b01, 7'd74, 7'd2));    // store BX
    ref_put16(8'd12, enc(2'b00, 7'd1,  7'd64));   // undefined
    ref_put16(8'd14, enc(2'b10, 7'd2,  7'd66));   // undefined
    ref_put16(8'd16, enc(2'b01, 7'd76, 7'd5));    // no register on either side
    ref_put16(8'd18, enc(2'b11, 7'd80, 7'd64));   // add without register
    ref_put16(8'd20, enc(2'b01, 7'd1,  7'd65));   // odd-address load
    ref_put16(8'd64, 16'h0001);
    ref_put16(8'd66, 16'h0002);
    ref_put16(8'd70, 16'hFFFF);
    ref_put16(8'd72, 16'h0002);
    ref_put16(8'd76, 16'hBBAA);
  endtask

  task automatic cmp_mem(string tag);
    int bad;
    bad = -1;
    for (int i = 64; i < LOAD_TOP; i++)
      if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
    if (bad < 0) check(tag, "data memory", 32'd0, 32'd0);
    else check(tag, $sformatf("memory byte %0d", bad), {24'd0, mem[bad]}, {24'd0, ref_mem[bad]});
  endtask

  task automatic run_prog();
    int retired, cyc, wecnt;
    bit first, pending;
    rst_n = 1'b0;
    for (int i = 0; i < LOAD_TOP; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_byte = ref_mem[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", {24'd0, pc_out}, 32'd0);
    check("R1", "ax in reset", {16'd0, ax_out}, 32'd0);
    check("R1", "bx in reset", {16'd0, bx_out}, 32'd0);
    check("R1", "we in reset", {31'd0, mem_we}, 32'd0);
    r_pc = 8'd0; r_ax = 16'd0; r_bx = 16'd0;
    rst_n = 1'b1;
    retired = 0; cyc = 0; wecnt = 0; first = 1; pending = 0;
    while (retired < N_INSTR && !finished) begin
      @(negedge clk);
      cyc++;
      if (mem_we) wecnt++;
      if (pending) begin
        check(exp_tag, "ax", {16'd0, ax_out}, {16'd0, r_ax});
        check(exp_tag, "bx", {16'd0, bx_out}, {16'd0, r_bx});
        check("R2", "pc", {24'd0, pc_out}, {24'd0, r_pc});
        cmp_mem(exp_tag);
        pending = 0;
      end
      if (retire) begin
        ref_step();
        check((exp_we != 0) ? "R5" : exp_tag, "write cycles", 32'(wecnt), 32'(exp_we));
        if (!first) check("R9", "instruction cycles", 32'(cyc), 32'(exp_len));
        first = 0; cyc = 0; wecnt = 0; pending = 1;
        retired++;
      end
    end
    @(negedge clk);
    check(exp_tag, "final ax", {16'd0, ax_out}, {16'd0, r_ax});
    check(exp_tag, "final bx", {16'd0, bx_out}, {16'd0, r_bx});
    check("R2", "final pc", {24'd0, pc_out}, {24'd0, r_pc});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    gen_directed();
    run_prog();
    // Directed results computed by hand from the requirements
    check("R6", "1 plus 2 stored", {16'd0, mem[69], mem[68]}, 32'h0003);
    check("R6", "FFFF plus 2 wraps", {16'd0, mem[75], mem[74]}, 32'h0001);
    check("R8", "no-register MOV left memory", {16'd0, mem[77], mem[76]}, 32'hBBAA);
    check("R3", "odd-address little-endian load", {16'd0, ax_out}, 32'h0200);
    check("R7", "bx after undefined opcodes", {16'd0, bx_out}, 32'h0001);
    for (int p = 1; p < N_PROGS && !finished; p++) begin
      gen_random();
      run_prog();
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule